// File: doc/BRIEF.md
# Three-Input Latching Multiplexer Slice

This block is a parameterised data-path element. It chooses among three input words with three independent gate strobes and can hold the chosen word across later cycles. The strobes are not a one-hot select. Each one adds its input word to a wired-OR bus, so two or three active strobes give the bitwise OR of those words. The word is built from identical one-bit slices, one per bit.

The hold-enable input sets the storage. While it is low, the stored word is forced to zero on every clock and the output shows only the gated inputs. On each clock edge while it is high, the stored word takes in the current bus value. The output then shows the stored word ORed with whatever is gated at that moment. A synchronous reset clears the stored word.

Top module: `mux3_hold_slice`

## Requirements
- R1: On a clock edge with `rst` high, the stored word becomes zero whatever the other inputs are. In the next cycle, with no strobe active, `dataOut` is 0.
- R2: With `holdEn` low and exactly one strobe high, `dataOut` equals that strobe's input word in the same cycle. `gateA` selects `dataA`, `gateB` selects `dataB` and `gateC` selects `dataC`.
- R3: With two or three strobes high, `dataOut` is the bitwise OR of the selected input words.
- R4: With `holdEn` low and no strobe high, `dataOut` is all zeros.
- R5: A clock edge with `holdEn` high stores the bus value. If `holdEn` then stays high and the strobes drop, `dataOut` keeps showing that value.
- R6: While `holdEn` stays high, each further edge ORs the gated inputs into the stored word. A stored bit never clears while `holdEn` is held.
- R7: While `holdEn` is low, the stored word has no effect on `dataOut`. After one edge with `holdEn` low, the stored word is zero, so raising `holdEn` again with no strobe high gives 0.
- R8: Each bit of the word behaves independently. The default width is 16 and is set by `WIDTH`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dataA | input | WIDTH | Input word A |
| dataB | input | WIDTH | Input word B |
| dataC | input | WIDTH | Input word C |
| gateA | input | 1 | Strobe that places A on the bus |
| gateB | input | 1 | Strobe that places B on the bus |
| gateC | input | 1 | Strobe that places C on the bus |
| holdEn | input | 1 | High: accumulate and show the stored word; low: clear it |
| dataOut | output | WIDTH | Bus OR stored word |

## Verification
The assertions assume that `rst` is high at the first clock edge, so the stored word starts from a known zero. They also assume that every input is stable and known at each edge. The bench holds reset for the opening cycles. It changes all inputs only on falling edges and gives every input a defined value at all times. The stimulus covers every strobe combination, hold periods of several lengths, and a reset that arrives while a word is being held with strobes active.

// File: rtl/mux3_hold_pkg.sv
package mux3_hold_pkg;
  localparam int NUM_INPUTS = 3;

  // strobes from control to every bit slice
  typedef struct packed {
    logic passA;   // put input A on the bus
    logic passB;   // put input B on the bus
    logic passC;   // put input C on the bus
    logic keep;    // next edge accumulates; low means next edge clears
    logic show;    // stored word visible at the output
  } strobe_t;
endpackage

// File: rtl/mux3_hold_ctrl.sv
module mux3_hold_ctrl
  import mux3_hold_pkg::*;
(
  input  logic    rst,
  input  logic    gateA,
  input  logic    gateB,
  input  logic    gateC,
  input  logic    holdEn,
  output strobe_t strobes
);
  always_comb begin
    strobes.passA = gateA;
    strobes.passB = gateB;
    strobes.passC = gateC;
    strobes.keep  = holdEn & ~rst;
    strobes.show  = holdEn;
  end
endmodule

// File: rtl/mux3_hold_bit.sv
module mux3_hold_bit
  import mux3_hold_pkg::*;
(
  input  logic    clk,
  input  logic    bitA,
  input  logic    bitB,
  input  logic    bitC,
  input  strobe_t strobes,
  output logic    bitOut
);
  logic busBit;
  logic heldQ;

  // wired-OR bus: each strobe adds its own input
  assign busBit = (bitA & strobes.passA) | (bitB & strobes.passB) | (bitC & strobes.passC);

  always_ff @(posedge clk) begin
    if (strobes.keep) heldQ <= heldQ | busBit;
    else              heldQ <= 1'b0;
  end

  assign bitOut = (heldQ & strobes.show) | busBit;
endmodule

// File: rtl/mux3_hold_path.sv
module mux3_hold_path
  import mux3_hold_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] wordA,
  input  logic [WIDTH-1:0] wordB,
  input  logic [WIDTH-1:0] wordC,
  input  strobe_t          strobes,
  output logic [WIDTH-1:0] wordOut
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    mux3_hold_bit u_bit (
      .clk    (clk),
      .bitA   (wordA[i]),
      .bitB   (wordB[i]),
      .bitC   (wordC[i]),
      .strobes(strobes),
      .bitOut (wordOut[i])
    );
  end
endmodule

// File: rtl/mux3_hold_slice.sv
module mux3_hold_slice
  import mux3_hold_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] dataA,
  input  logic [WIDTH-1:0] dataB,
  input  logic [WIDTH-1:0] dataC,
  input  logic             gateA,
  input  logic             gateB,
  input  logic             gateC,
  input  logic             holdEn,
  output logic [WIDTH-1:0] dataOut
);
  strobe_t strobes;

  mux3_hold_ctrl u_ctrl (
    .rst    (rst),
    .gateA  (gateA),
    .gateB  (gateB),
    .gateC  (gateC),
    .holdEn (holdEn),
    .strobes(strobes)
  );

  mux3_hold_path #(.WIDTH(WIDTH)) u_path (
    .clk    (clk),
    .wordA  (dataA),
    .wordB  (dataB),
    .wordC  (dataC),
    .strobes(strobes),
    .wordOut(dataOut)
  );
endmodule

// File: rtl/mux3_hold_chk.sv
module mux3_hold_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] dataA,
  input logic [WIDTH-1:0] dataB,
  input logic [WIDTH-1:0] dataC,
  input logic             gateA,
  input logic             gateB,
  input logic             gateC,
  input logic             holdEn,
  input logic [WIDTH-1:0] dataOut
);
  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> ((!gateA && !gateB && !gateC) -> dataOut == '0));

  // R2
  single_a_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (!holdEn && gateA && !gateB && !gateC) |-> dataOut == dataA);

  // R3
  pair_or_chk: assert property (@(posedge clk) disable iff (rst)
    (!holdEn && gateB && gateC && !gateA) |-> dataOut == (dataB | dataC));

  // R4
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!holdEn && !gateA && !gateB && !gateC) |-> dataOut == '0);

  // R5
  capture_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (holdEn ##1 holdEn) |-> ((dataOut & $past(dataOut)) == $past(dataOut)));

  // R7
  cleared_after_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!holdEn ##1 (holdEn && !gateA && !gateB && !gateC)) |-> dataOut == '0);
endmodule

bind mux3_hold_slice mux3_hold_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .dataA(dataA), .dataB(dataB), .dataC(dataC),
  .gateA(gateA), .gateB(gateB), .gateC(gateC), .holdEn(holdEn), .dataOut(dataOut)
);

// File: tb/mux3_hold_slice_tb.sv
module mux3_hold_slice_tb;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] dataA = '0, dataB = '0, dataC = '0;
  logic         gateA = 1'b0, gateB = 1'b0, gateC = 1'b0, holdEn = 1'b0;
  logic [W-1:0] dataOut;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  logic [W-1:0] modelHeld = '0;

  always #10 clk = ~clk;   // 50 MHz

  mux3_hold_slice #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .dataA(dataA), .dataB(dataB), .dataC(dataC),
    .gateA(gateA), .gateB(gateB), .gateC(gateC), .holdEn(holdEn), .dataOut(dataOut)
  );

  // apply one vector at a falling edge, check mid-cycle, update the model at the rising edge
  task automatic step(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c,
                      input logic ga, input logic gb, input logic gc,
                      input logic h, input logic r, input string req);
    logic [W-1:0] bus;
    logic [W-1:0] expOut;
    @(negedge clk);
    dataA = a; dataB = b; dataC = c;
    gateA = ga; gateB = gb; gateC = gc; holdEn = h; rst = r;
    #2;
    bus = (ga ? a : '0) | (gb ? b : '0) | (gc ? c : '0);
    expOut = (h ? modelHeld : '0) | bus;
    vectors++;
    if (dataOut !== expOut) begin
      errors++;
      $display("FAIL %s: dataOut=%h expected=%h", req, dataOut, expOut);
    end
    @(posedge clk);
    if (r)      modelHeld = '0;
    else if (h) modelHeld = modelHeld | bus;
    else        modelHeld = '0;
  endtask

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog: cycles=%0d expected=<100000", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    step('1, '1, '1, 1, 1, 1, 1, 1, "R1");
    step('0, '0, '0, 0, 0, 0, 1, 0, "R1");
    // R4: idle gives zero
    step(16'hFFFF, 16'hFFFF, 16'hFFFF, 0, 0, 0, 0, 0, "R4");
    // R2: each strobe alone
    step(16'h1234, 16'hABCD, 16'h0F0F, 1, 0, 0, 0, 0, "R2");
    step(16'h1234, 16'hABCD, 16'h0F0F, 0, 1, 0, 0, 0, "R2");
    step(16'h1234, 16'hABCD, 16'h0F0F, 0, 0, 1, 0, 0, "R2");
    // R3: combinations OR together
    step(16'h00F0, 16'h0F00, 16'hF000, 1, 1, 0, 0, 0, "R3");
    step(16'h00F0, 16'h0F00, 16'hF000, 0, 1, 1, 0, 0, "R3");
    step(16'h00F0, 16'h0F00, 16'hF000, 1, 1, 1, 0, 0, "R3");
    // R5: capture, then strobes drop
    step(16'h5A00, '0, '0, 1, 0, 0, 1, 0, "R5");
    step(16'hFFFF, 16'hFFFF, 16'hFFFF, 0, 0, 0, 1, 0, "R5");
    step('0, '0, '0, 0, 0, 0, 1, 0, "R5");
    // R6: accumulate more bits while held
    step('0, 16'h00A5, '0, 0, 1, 0, 1, 0, "R6");
    step('0, '0, '0, 0, 0, 0, 1, 0, "R6");
    step('0, '0, 16'h0300, 0, 0, 1, 1, 0, "R6");
    step('0, '0, '0, 0, 0, 0, 1, 0, "R6");
    // R7: low hides stored word, then clears it
    step('0, '0, '0, 0, 0, 0, 0, 0, "R7");
    step('0, '0, '0, 0, 0, 0, 1, 0, "R7");
    step(16'h0001, '0, '0, 1, 0, 0, 0, 0, "R7");
    // R1: reset while holding with strobes active
    step(16'hC3C3, '0, '0, 1, 0, 0, 1, 0, "R1");
    step(16'h3C3C, '0, '0, 1, 0, 0, 1, 1, "R1");
    step('0, '0, '0, 0, 0, 0, 1, 0, "R1");
    // R8: independent bits, walking ones through hold
    for (int i = 0; i < W; i++)
      step(W'(1) << i, '0, '0, 1, 0, 0, 1, 0, "R8");
    step('0, '0, '0, 0, 0, 0, 1, 0, "R8");
    step('0, '0, '0, 0, 0, 0, 0, 0, "R8");
    // R6: mixed phase
    for (int i = 0; i < 300; i++)
      step(W'($urandom), W'($urandom), W'($urandom),
           1'($urandom), 1'($urandom), 1'($urandom),
           ($urandom % 4) != 0, ($urandom % 50) == 0, "R6");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule